// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Read Cache

This block is a direct-mapped read cache whose lines are divided into sub-blocks. A line keeps a single address tag that all of its sub-blocks share, and each sub-block has its own valid bit. Storing one tag per large line keeps tag storage small. Because the valid state is tracked per sub-block, a miss only fetches the sub-block that was asked for, not the whole line, which keeps the miss penalty short.

A lookup compares the tag and checks the valid bit of the addressed sub-block. A hit needs both conditions. So an address can match the tag and still miss, because its sub-block has not been fetched yet. When the tag does not match, the line takes the new tag and every valid bit of that line is cleared. Then the one needed sub-block is filled.

Addresses are word addresses. With the default geometry (16 lines, 4 sub-blocks of 2 words, 32-bit words, 16-bit addresses) the fields are:

- bit 0: the word inside the sub-block
- bits 2:1: the sub-block
- bits 6:3: the line
- bits 15:7: the tag

Every interface uses a valid/ready handshake:

- A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` stays low from the moment a request is taken until its response has been accepted, so at most one read is in flight.
- A response offered on `rsp_valid` is held, unchanged, until `rsp_ready` accepts it.
- A memory request is held with a stable address until `mem_req_ready` is high.
- Fill data beats are taken only while `mem_rsp_ready` is high. A beat whose `mem_rsp_valid` is low is simply waited for.

Top module: `sbc_cache`

## Requirements
- R1: Reset clears every sub-block valid bit. The first read of any address after reset is a miss. While reset is applied and just after it, `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0 and `mem_rsp_ready`=0.
- R2: A read whose tag matches and whose sub-block is valid is a hit. It returns the stored word with `rsp_hit`=1 on the cycle after acceptance and makes no memory request.
- R3: A read whose tag matches but whose sub-block is invalid is a miss. It requests exactly that sub-block: `mem_req_addr` is the read address with its word-offset bits (bit 0 by default) forced to zero.
- R4: A fill is a burst of WPS beats, stored in word order starting at offset 0. The valid bit is set only after the last beat. The response carries the requested word with `rsp_hit`=0 and appears on the cycle after the last beat. No response is offered while beats are still outstanding.
- R5: A read whose tag differs from the line's tag replaces the tag and clears all valid bits of that line. Sub-blocks of that line that were valid before then miss again.
- R6: Filling one sub-block leaves the other valid sub-blocks of the same line valid. They still hit.
- R7: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_data` and `rsp_hit` stay unchanged and `req_ready` stays 0.
- R8: While `mem_req_valid`=1 and `mem_req_ready`=0, the request stays raised and `mem_req_addr` stays unchanged.
- R9: A fill or tag replacement in one line does not change the tag or valid bits of any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Cache can take a request |
| req_addr | input | AW | Word address of the read |
| rsp_valid | output | 1 | Read data offered |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | DW | Word read |
| rsp_hit | output | 1 | 1 when served without a fill |
| mem_req_valid | output | 1 | Sub-block fetch requested |
| mem_req_ready | input | 1 | Memory takes the fetch request |
| mem_req_addr | output | AW | Word address of the sub-block's first word |
| mem_rsp_valid | input | 1 | Fill beat offered |
| mem_rsp_ready | output | 1 | Cache takes fill beats |
| mem_rsp_data | input | DW | Fill beat data |

## Verification
Count cycles from the clock edge that accepts a request:

- A hit shows `rsp_valid` on the next cycle.
- A miss raises `mem_req_valid` on the next cycle. The fill runs one beat per cycle once the memory handshake completes, and the response appears one cycle after the last beat. With a memory that answers at once, that is 2+WPS cycles after acceptance.

The bench samples every output at the falling clock edge and counts falling edges from the one after acceptance. It checks that this count equals 1 for a hit and 2+WPS for a miss against a prompt memory. Against a stalling memory it skips the latency check and instead checks, at each falling edge, that the request address is held and that no response appears before the burst ends.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // Controller phases of one read transaction.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for a request, lookup happens here
    ST_MREQ = 2'd1,  // sub-block fetch request raised
    ST_FILL = 2'd2,  // collecting burst beats
    ST_RESP = 2'd3   // read result offered
  } sbc_state_e;

endpackage

// File: rtl/sbc_tag_store.sv
module sbc_tag_store #(
  parameter int LINES = 16,
  parameter int SUBS  = 4,
  parameter int TAG_W = 9,
  parameter int IDX_W = $clog2(LINES),
  parameter int SUB_W = $clog2(SUBS)
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [SUB_W-1:0] rd_sub,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             tag_match,
  output logic             sub_valid,
  // tag replacement: new tag, all sub-block valids of the line cleared
  input  logic             repl_en,
  input  logic [IDX_W-1:0] repl_idx,
  input  logic [TAG_W-1:0] repl_tag,
  // fill completion: one sub-block becomes valid
  input  logic             fill_done,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [SUB_W-1:0] fill_sub
);

  logic [TAG_W-1:0] tag_w [LINES];
  logic [SUBS-1:0]  vld_w [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [TAG_W-1:0] tag_q;
    logic [SUBS-1:0]  vld_q;
    logic             sel_repl;
    logic             sel_fill;

    assign sel_repl = repl_en   && (repl_idx == IDX_W'(g));
    assign sel_fill = fill_done && (fill_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q <= '0;
        vld_q <= '0;
      end else if (sel_repl) begin
        tag_q <= repl_tag;
        vld_q <= '0;
      end else if (sel_fill) begin
        vld_q[fill_sub] <= 1'b1;
      end
    end

    assign tag_w[g] = tag_q;
    assign vld_w[g] = vld_q;
  end

  always_comb begin
    tag_match = (tag_w[rd_idx] == rd_tag);
    sub_valid = vld_w[rd_idx][rd_sub];
  end

endmodule

// File: rtl/sbc_data_store.sv
module sbc_data_store #(
  parameter int LINES = 16,
  parameter int SUBS  = 4,
  parameter int WPS   = 2,
  parameter int DW    = 32,
  parameter int IDX_W = $clog2(LINES),
  parameter int SUB_W = $clog2(SUBS),
  parameter int OFF_W = $clog2(WPS)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [SUB_W-1:0] rd_sub,
  input  logic [OFF_W-1:0] rd_off,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SUB_W-1:0] wr_sub,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [DW-1:0]    wr_data
);

  localparam int ADDR_W = IDX_W + SUB_W + OFF_W;
  localparam int DEPTH  = LINES * SUBS * WPS;

  logic [DW-1:0]     mem_q [DEPTH];
  logic [ADDR_W-1:0] rd_a;
  logic [ADDR_W-1:0] wr_a;

  assign rd_a = {rd_idx, rd_sub, rd_off};
  assign wr_a = {wr_idx, wr_sub, wr_off};

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_a] <= wr_data;
  end

  assign rd_data = mem_q[rd_a];

endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int WPS   = 2,
  parameter int TAG_W = 9,
  parameter int IDX_W = 4,
  parameter int SUB_W = 2,
  parameter int OFF_W = $clog2(WPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  // processor request and lookup results
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [SUB_W-1:0] req_sub,
  input  logic [OFF_W-1:0] req_off,
  input  logic             tag_match,
  input  logic             sub_valid,
  input  logic [DW-1:0]    rd_data,
  // processor response
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_hit,
  // memory side
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [DW-1:0]    mem_rsp_data,
  // store updates
  output logic             repl_en,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [SUB_W-1:0] wr_sub,
  output logic [OFF_W-1:0] wr_off,
  output logic             fill_done
);

  sbc_state_e       state_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;
  logic [SUB_W-1:0] sub_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] beat_q;
  logic [DW-1:0]    data_q;
  logic             hit_q;

  logic req_fire;
  logic lookup_hit;
  logic beat_fire;
  logic beat_last;

  assign req_ready     = (state_q == ST_IDLE);
  assign req_fire      = req_valid && req_ready;
  assign lookup_hit    = tag_match && sub_valid;
  assign beat_fire     = (state_q == ST_FILL) && mem_rsp_valid;
  assign beat_last     = (beat_q == OFF_W'(WPS - 1));

  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_data      = data_q;
  assign rsp_hit       = hit_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = {tag_q, idx_q, sub_q, {OFF_W{1'b0}}};
  assign mem_rsp_ready = (state_q == ST_FILL);

  // A mismatching tag is swapped in at the accepting edge, which also
  // clears the line's valid bits before any beat arrives.
  assign repl_en   = req_fire && !tag_match;
  assign wr_en     = beat_fire;
  assign wr_idx    = idx_q;
  assign wr_sub    = sub_q;
  assign wr_off    = beat_q;
  assign fill_done = beat_fire && beat_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      idx_q   <= '0;
      sub_q   <= '0;
      off_q   <= '0;
      beat_q  <= '0;
      data_q  <= '0;
      hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            tag_q <= req_tag;
            idx_q <= req_idx;
            sub_q <= req_sub;
            off_q <= req_off;
            if (lookup_hit) begin
              data_q  <= rd_data;
              hit_q   <= 1'b1;
              state_q <= ST_RESP;
            end else begin
              state_q <= ST_MREQ;
            end
          end
        end
        ST_MREQ: begin
          if (mem_req_ready) begin
            beat_q  <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (beat_fire) begin
            if (beat_q == off_q) data_q <= mem_rsp_data;
            beat_q <= beat_q + OFF_W'(1);
            if (beat_last) begin
              hit_q   <= 1'b0;
              state_q <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbc_cache.sv
module sbc_cache #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int SUBS  = 4,
  parameter int WPS   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_hit,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data
);

  localparam int OFF_W = $clog2(WPS);
  localparam int SUB_W = $clog2(SUBS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - OFF_W - SUB_W - IDX_W;

  logic [OFF_W-1:0] a_off;
  logic [SUB_W-1:0] a_sub;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;

  assign {a_tag, a_idx, a_sub, a_off} = req_addr;

  logic             tag_match;
  logic             sub_valid;
  logic [DW-1:0]    rd_data;
  logic             repl_en;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [SUB_W-1:0] wr_sub;
  logic [OFF_W-1:0] wr_off;
  logic             fill_done;

  sbc_tag_store #(
    .LINES(LINES), .SUBS(SUBS), .TAG_W(TAG_W), .IDX_W(IDX_W), .SUB_W(SUB_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (a_idx),
    .rd_sub    (a_sub),
    .rd_tag    (a_tag),
    .tag_match (tag_match),
    .sub_valid (sub_valid),
    .repl_en   (repl_en),
    .repl_idx  (a_idx),
    .repl_tag  (a_tag),
    .fill_done (fill_done),
    .fill_idx  (wr_idx),
    .fill_sub  (wr_sub)
  );

  sbc_data_store #(
    .LINES(LINES), .SUBS(SUBS), .WPS(WPS), .DW(DW),
    .IDX_W(IDX_W), .SUB_W(SUB_W), .OFF_W(OFF_W)
  ) u_data (
    .clk     (clk),
    .rd_idx  (a_idx),
    .rd_sub  (a_sub),
    .rd_off  (a_off),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_sub  (wr_sub),
    .wr_off  (wr_off),
    .wr_data (mem_rsp_data)
  );

  sbc_ctrl #(
    .AW(AW), .DW(DW), .WPS(WPS), .TAG_W(TAG_W),
    .IDX_W(IDX_W), .SUB_W(SUB_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_tag       (a_tag),
    .req_idx       (a_idx),
    .req_sub       (a_sub),
    .req_off       (a_off),
    .tag_match     (tag_match),
    .sub_valid     (sub_valid),
    .rd_data       (rd_data),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .rsp_hit       (rsp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .repl_en       (repl_en),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_sub        (wr_sub),
    .wr_off        (wr_off),
    .fill_done     (fill_done)
  );

endmodule

// File: rtl/sbc_cache_chk.sv
module sbc_cache_chk #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int WPS = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_hit,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_ready
);

  localparam int OFF_W = $clog2(WPS);

  // Beats taken since the last accepted response.
  logic [15:0] beats_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      beats_q <= '0;
    else if (rsp_valid && rsp_ready) beats_q <= '0;
    else if (mem_rsp_valid && mem_rsp_ready) beats_q <= beats_q + 16'd1;
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !rsp_valid && !mem_req_valid && !mem_rsp_ready));

  assert_accept_acts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || mem_req_valid));

  assert_hit_no_beats_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_hit) |-> (beats_q == 16'd0));

  assert_fetch_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && !rsp_hit) |-> (beats_q == 16'(WPS)));

  assert_fill_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> (!mem_req_valid && !rsp_valid && !req_ready));

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_hit) && !req_ready));

  assert_memreq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

bind sbc_cache sbc_cache_chk #(.AW(AW), .DW(DW), .WPS(WPS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .rsp_hit       (rsp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready)
);

// File: tb/tb_sbc_cache.sv
module tb_sbc_cache;

  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int WPS = 2;
  localparam int NV  = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          rsp_valid;
  logic          rsp_ready;
  logic [DW-1:0] rsp_data;
  logic          rsp_hit;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic          mem_rsp_ready;
  logic [DW-1:0] mem_rsp_data;

  always #10 clk = ~clk;

  sbc_cache #(.AW(AW), .DW(DW), .LINES(16), .SUBS(4), .WPS(WPS)) dut (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a, ~a} ^ 32'h5A3C_96E1;
  endfunction

  // Memory model: mem_slow adds request stalls and beat bubbles.
  bit            mem_slow = 1'b0;
  int            mreq_cnt = 0;
  logic [AW-1:0] mreq_last = '0;
  logic [AW-1:0] mbase;

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        mbase = mem_req_addr;
        if (mem_slow) begin
          for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            check(mem_req_valid && (mem_req_addr == mbase), "R8",
                  "fetch request held while stalled", 64'(mem_req_addr), 64'(mbase));
          end
        end
        mem_req_ready = 1'b1;
        mreq_cnt++;
        mreq_last = mbase;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < WPS; i++) begin
          if (mem_slow) begin
            mem_rsp_valid = 1'b0;
            @(negedge clk);
            check(!rsp_valid, "R4", "no response during burst",
                  64'(rsp_valid), 64'd0);
          end
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(mbase + AW'(i));
          @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // One read; exp_lat < 0 skips the latency check; hold > 0 stalls rsp_ready.
  task automatic do_read(input logic [AW-1:0] a, input bit exp_hit,
                         input int exp_lat, input string req, input int hold);
    int lat;
    int mc0;
    logic [DW-1:0] d0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    mc0 = mreq_cnt;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(rsp_valid, req, "response offered", 64'(rsp_valid), 64'd1);
    check(rsp_data == mem_word(a), req, $sformatf("data @%h", a),
          64'(rsp_data), 64'(mem_word(a)));
    check(rsp_hit == exp_hit, req, $sformatf("hit flag @%h", a),
          64'(rsp_hit), 64'(exp_hit));
    if (exp_lat > 0)
      check(lat == exp_lat, req, $sformatf("latency @%h", a), 64'(lat), 64'(exp_lat));
    check((mreq_cnt - mc0) == (exp_hit ? 0 : 1), req, $sformatf("fetch count @%h", a),
          64'(mreq_cnt - mc0), 64'(exp_hit ? 0 : 1));
    if (!exp_hit)
      check(mreq_last == (a & ~AW'(WPS - 1)), req, $sformatf("fetch address @%h", a),
            64'(mreq_last), 64'(a & ~AW'(WPS - 1)));
    d0 = rsp_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid && (rsp_data == d0) && !req_ready, "R7",
            "response held under back-pressure", 64'(rsp_data), 64'(d0));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R7", "idle after response taken",
          64'({rsp_valid, req_ready}), 64'b01);
  endtask

  // {requirement number, expected hit, word address}
  // Address fields: [0] word, [2:1] sub-block, [6:3] line, [15:7] tag.
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 4'd0, 16'h0000},  // R1 cold miss
    {4'd2, 4'd1, 16'h0001},  // R2 other word, same sub-block
    {4'd3, 4'd0, 16'h0002},  // R3 tag hit, sub-block 1 invalid
    {4'd6, 4'd1, 16'h0000},  // R6 sub-block 0 survives sub-block 1 fill
    {4'd6, 4'd1, 16'h0003},  // R6
    {4'd5, 4'd0, 16'h0080},  // R5 new tag in line 0
    {4'd5, 4'd0, 16'h0002},  // R5 old tag back, sub-block 1 was cleared
    {4'd5, 4'd0, 16'h0000},  // R5 sub-block 0 cleared too
    {4'd9, 4'd0, 16'h0008},  // R9 line 1 fill
    {4'd9, 4'd1, 16'h0001},  // R9 line 0 untouched
    {4'd3, 4'd0, 16'h000F},  // R3 line 1 sub-block 3, odd word
    {4'd2, 4'd1, 16'h000E},  // R2
    {4'd4, 4'd0, 16'h07F9},  // R4 line 15, requested word second in burst
    {4'd4, 4'd1, 16'h07F8},  // R4 first word stored too
    {4'd5, 4'd0, 16'hFFFF},  // R5 top tag replaces line 15
    {4'd5, 4'd0, 16'h07F8}   // R5 former contents gone
  };

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready && !rsp_valid && !mem_req_valid && !mem_rsp_ready, "R1",
          "outputs in reset",
          64'({req_ready, rsp_valid, mem_req_valid, mem_rsp_ready}), 64'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R1", "outputs after reset",
          64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);

    for (int v = 0; v < NV; v++) begin
      do_read(VEC[v][15:0], VEC[v][16], VEC[v][16] ? 1 : 2 + WPS,
              $sformatf("R%0d", VEC[v][23:20]), 0);
    end

    // R7: hit held under back-pressure, then a miss held too
    do_read(16'h0001, 1'b1, 1, "R7", 3);
    do_read(16'h0104, 1'b0, 2 + WPS, "R7", 2);

    // R8 / R4: stalling memory, miss then hit on the same sub-block
    mem_slow = 1'b1;
    do_read(16'h0245, 1'b0, -1, "R8", 0);
    do_read(16'h0244, 1'b1, 1, "R4", 0);
    mem_slow = 1'b0;

    // R1: reset again wipes previously valid sub-blocks
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_read(16'h0001, 1'b0, 2 + WPS, "R1", 0);
    do_read(16'h0244, 1'b0, 2 + WPS, "R1", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule